// File: doc/BRIEF.md
# Hierarchical Scan Region Controller

This block splits scan testing into a set of separately tested regions so that only one region's scan chains shift at any moment. It passes the chip-level scan-enable to exactly one region, named by a select value. It drives every other region's scan-enable to 0, so those regions stay in functional mode and switch at roughly their normal rate. Keeping scan shifting to one region bounds the supply droop during test.

The applied select is held in a register. It is only reloaded while the global scan-enable is low, so a region can never be swapped in the middle of a shift. In manual mode the select comes from an input. In auto mode a sequencer walks the regions in ascending order. A start pulse launches the walk, and each session-done pulse from the pattern source moves to the next region. After the last region the block pulses all-done and goes back to idle.

Top module: `scan_region_ctrl`

## Requirements
- R1: At most one bit of the per-region scan-enable vector is 1 in any cycle.
- R2: In test mode, manual mode, with an applied select k below the region count, region k's scan-enable equals the global scan-enable in the same cycle, and all other regions read 0.
- R3: While test mode is low, every per-region scan-enable is 0 whatever the select or global scan-enable, and the error flag is 0.
- R4: The applied select (active_sel_o) is reloaded at a clock edge only when the global scan-enable is low at that edge. A select change made while the global scan-enable is high takes effect at the first edge where it is low.
- R5: In manual test mode, an applied select equal to or above the region count enables no region and sets sel_err_o to 1. sel_err_o is 0 for an in-range select.
- R6: In auto mode, a start pulse while idle raises busy_o at the next edge and applies region 0 at the following edge where scan-enable is low. Each session-done pulse while busy advances the region index by one.
- R7: The session-done pulse for the last region drops busy_o and raises all_done_o at the same edge. all_done_o stays high for exactly one cycle.
- R8: In auto mode while not busy, no region is enabled and session-done has no effect. A start pulse while busy leaves the current region unchanged.
- R9: During and right after reset, active_sel_o is 0, busy_o and all_done_o are 0, and no region is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode_i | input | 1 | Scan test mode active |
| scan_en_i | input | 1 | Global scan-enable |
| auto_mode_i | input | 1 | 1 selects the internal sequencer, 0 selects the sel_i input |
| sel_i | input | SEL_W | Requested region in manual mode |
| start_i | input | 1 | Starts an auto-mode walk of all regions |
| session_done_i | input | 1 | Pattern source has finished the current region |
| region_se_o | output | NUM_REGIONS | Per-region scan-enable, one-hot or zero |
| active_sel_o | output | SEL_W | Currently applied select |
| busy_o | output | 1 | Auto walk in progress |
| all_done_o | output | 1 | One-cycle pulse after the last region finishes |
| sel_err_o | output | 1 | Applied manual select is out of range |

## Verification
The bench changes the select in the middle of a shift. A controller that skipped the hold-off would move scan-enable to a different region while chains are still shifting. It drives select values past the last region. A decoder that dropped the range check would alias these to a low region instead of enabling nothing and flagging an error. The auto walk is driven through all regions, with stray start and session-done pulses mixed in. Off-by-one sequencing would skip region 0 or repeat the last region, would fire all-done early or hold it high, and would let a stray pulse restart or advance the walk.

// File: rtl/scan_region_pkg.sv
package scan_region_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  // Width of the select value: one spare bit above the index width so that
  // out-of-range selects can be presented and flagged.
  function automatic int unsigned sel_width(int unsigned regions);
    return $clog2(regions) + 1;
  endfunction

  function automatic logic idx_in_range(int unsigned idx, int unsigned regions);
    return idx < regions;
  endfunction

  function automatic logic idx_is_last(int unsigned idx, int unsigned regions);
    return (idx + 1) == regions;
  endfunction

endpackage

// File: rtl/region_sel_hold.sv
module region_sel_hold #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_en_i,
  input  logic [SEL_W-1:0] req_sel_i,
  output logic [SEL_W-1:0] applied_sel_o,
  output logic             commit_o
);

  logic [SEL_W-1:0] applied_q;

  // A new select is accepted only between shift bursts.
  assign commit_o = ~scan_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      applied_q <= '0;
    end else if (commit_o) begin
      applied_q <= req_sel_i;
    end
  end

  assign applied_sel_o = applied_q;

endmodule

// File: rtl/region_sequencer.sv
module region_sequencer
  import scan_region_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int IDX_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             start_i,
  input  logic             session_done_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             busy_o,
  output logic             all_done_o,
  output logic             advance_o,
  output logic             finish_o
);

  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;
  logic             at_last;

  assign at_last   = idx_is_last(int'(idx_q), NUM_REGIONS);
  assign advance_o = enable_i && (state_q == SEQ_RUN) && session_done_i;
  assign finish_o  = advance_o && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= finish_o;
      if (!enable_i) begin
        state_q <= SEQ_IDLE;
        idx_q   <= '0;
      end else begin
        case (state_q)
          SEQ_IDLE: begin
            if (start_i) begin
              state_q <= SEQ_RUN;
              idx_q   <= '0;
            end
          end
          SEQ_RUN: begin
            if (finish_o) begin
              state_q <= SEQ_IDLE;
              idx_q   <= '0;
            end else if (advance_o) begin
              idx_q <= idx_q + 1'b1;
            end
          end
          default: state_q <= SEQ_IDLE;
        endcase
      end
    end
  end

  assign idx_o      = idx_q;
  assign busy_o     = (state_q == SEQ_RUN);
  assign all_done_o = done_q;

endmodule

// File: rtl/region_gate.sv
module region_gate
  import scan_region_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int SEL_W       = 4
) (
  input  logic                   test_mode_i,
  input  logic                   scan_en_i,
  input  logic                   allow_i,
  input  logic [SEL_W-1:0]       sel_i,
  output logic [NUM_REGIONS-1:0] region_se_o,
  output logic                   sel_err_o
);

  logic             sel_ok;
  logic             pass_se;

  assign sel_ok  = idx_in_range(int'(sel_i), NUM_REGIONS);
  assign pass_se = scan_en_i & test_mode_i & allow_i;

  for (genvar k = 0; k < NUM_REGIONS; k++) begin : g_region
    assign region_se_o[k] = pass_se && (sel_i == SEL_W'(k));
  end

  assign sel_err_o = test_mode_i & allow_i & ~sel_ok;

endmodule

// File: rtl/scan_region_ctrl.sv
module scan_region_ctrl
  import scan_region_pkg::*;
#(
  parameter  int NUM_REGIONS = 8,
  localparam int IDX_W       = $clog2(NUM_REGIONS),
  localparam int SEL_W       = sel_width(NUM_REGIONS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   test_mode_i,
  input  logic                   scan_en_i,
  input  logic                   auto_mode_i,
  input  logic [SEL_W-1:0]       sel_i,
  input  logic                   start_i,
  input  logic                   session_done_i,
  output logic [NUM_REGIONS-1:0] region_se_o,
  output logic [SEL_W-1:0]       active_sel_o,
  output logic                   busy_o,
  output logic                   all_done_o,
  output logic                   sel_err_o
);

  if (NUM_REGIONS < 8) begin : g_region_count_check
    $error("scan_region_ctrl needs at least 8 regions");
  end

  logic             seq_enable;
  logic [IDX_W-1:0] seq_idx;
  logic             seq_busy;
  logic             seq_advance;
  logic             seq_finish;
  logic [SEL_W-1:0] req_sel;
  logic [SEL_W-1:0] applied_sel;
  logic             sel_commit;
  logic             gate_allow;

  assign seq_enable = auto_mode_i & test_mode_i;

  region_sequencer #(
    .NUM_REGIONS (NUM_REGIONS),
    .IDX_W       (IDX_W)
  ) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .enable_i       (seq_enable),
    .start_i        (start_i),
    .session_done_i (session_done_i),
    .idx_o          (seq_idx),
    .busy_o         (seq_busy),
    .all_done_o     (all_done_o),
    .advance_o      (seq_advance),
    .finish_o       (seq_finish)
  );

  assign req_sel = auto_mode_i ? {1'b0, seq_idx} : sel_i;

  region_sel_hold #(
    .SEL_W (SEL_W)
  ) u_hold (
    .clk           (clk),
    .rst_n         (rst_n),
    .scan_en_i     (scan_en_i),
    .req_sel_i     (req_sel),
    .applied_sel_o (applied_sel),
    .commit_o      (sel_commit)
  );

  assign gate_allow = ~auto_mode_i | seq_busy;

  region_gate #(
    .NUM_REGIONS (NUM_REGIONS),
    .SEL_W       (SEL_W)
  ) u_gate (
    .test_mode_i (test_mode_i),
    .scan_en_i   (scan_en_i),
    .allow_i     (gate_allow),
    .sel_i       (applied_sel),
    .region_se_o (region_se_o),
    .sel_err_o   (sel_err_o)
  );

  assign active_sel_o = applied_sel;
  assign busy_o       = seq_busy;

endmodule

// File: rtl/scan_region_ctrl_chk.sv
module scan_region_ctrl_chk #(
  parameter int NUM_REGIONS = 8,
  parameter int SEL_W       = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   test_mode_i,
  input logic                   scan_en_i,
  input logic                   auto_mode_i,
  input logic                   session_done_i,
  input logic [NUM_REGIONS-1:0] region_se_o,
  input logic [SEL_W-1:0]       active_sel_o,
  input logic                   busy_o,
  input logic                   all_done_o,
  input logic                   sel_err_o,
  input logic                   seq_advance,
  input logic                   sel_commit
);

  assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(region_se_o));

  assert_se_low_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en_i |-> (region_se_o == '0));

  assert_no_test_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode_i |-> (region_se_o == '0) && !sel_err_o);

  assert_holdoff_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(scan_en_i) |-> $stable(active_sel_o));

  assert_commit_only_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en_i |-> !sel_commit);

  assert_err_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_err_o |-> (region_se_o == '0));

  assert_advance_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    seq_advance |-> busy_o && session_done_i);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    all_done_o |=> !all_done_o);

  assert_done_after_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    all_done_o |-> !busy_o && $past(busy_o) && $past(session_done_i));

  assert_auto_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_mode_i && !busy_o) |-> (region_se_o == '0));

endmodule

bind scan_region_ctrl scan_region_ctrl_chk #(
  .NUM_REGIONS (NUM_REGIONS),
  .SEL_W       (SEL_W)
) i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .test_mode_i    (test_mode_i),
  .scan_en_i      (scan_en_i),
  .auto_mode_i    (auto_mode_i),
  .session_done_i (session_done_i),
  .region_se_o    (region_se_o),
  .active_sel_o   (active_sel_o),
  .busy_o         (busy_o),
  .all_done_o     (all_done_o),
  .sel_err_o      (sel_err_o),
  .seq_advance    (seq_advance),
  .sel_commit     (sel_commit)
);

// File: tb/test_scan_region_ctrl.sv
module test_scan_region_ctrl;

  localparam int NR = 8;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          test_mode_i = 1'b0;
  logic          scan_en_i = 1'b0;
  logic          auto_mode_i = 1'b0;
  logic [SW-1:0] sel_i = '0;
  logic          start_i = 1'b0;
  logic          session_done_i = 1'b0;
  logic [NR-1:0] region_se_o;
  logic [SW-1:0] active_sel_o;
  logic          busy_o;
  logic          all_done_o;
  logic          sel_err_o;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #2.5 clk = ~clk;

  scan_region_ctrl #(.NUM_REGIONS(NR)) i_scan_region_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .test_mode_i    (test_mode_i),
    .scan_en_i      (scan_en_i),
    .auto_mode_i    (auto_mode_i),
    .sel_i          (sel_i),
    .start_i        (start_i),
    .session_done_i (session_done_i),
    .region_se_o    (region_se_o),
    .active_sel_o   (active_sel_o),
    .busy_o         (busy_o),
    .all_done_o     (all_done_o),
    .sel_err_o      (sel_err_o)
  );

  // {test_mode, scan_en, sel[3:0], exp_err, pad, exp_region_se[7:0]}
  localparam logic [15:0] VECS [10] = '{
    {1'b1, 1'b1, 4'd0,  1'b0, 1'b0, 8'h01},
    {1'b1, 1'b1, 4'd3,  1'b0, 1'b0, 8'h08},
    {1'b1, 1'b1, 4'd7,  1'b0, 1'b0, 8'h80},
    {1'b1, 1'b0, 4'd5,  1'b0, 1'b0, 8'h00},
    {0'b0 == 0 ? 1'b0 : 1'b0, 1'b1, 4'd2, 1'b0, 1'b0, 8'h00},
    {1'b0, 1'b1, 4'd9,  1'b0, 1'b0, 8'h00},
    {1'b1, 1'b1, 4'd8,  1'b1, 1'b0, 8'h00},
    {1'b1, 1'b1, 4'd15, 1'b1, 1'b0, 8'h00},
    {1'b1, 1'b0, 4'd12, 1'b1, 1'b0, 8'h00},
    {1'b1, 1'b1, 4'd4,  1'b0, 1'b0, 8'h10}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    // R9: reset state, with a select already requested
    sel_i = 4'd3;
    repeat (3) tick();
    chk("R9 active_sel in reset", 32'(active_sel_o), 0);
    chk("R9 busy in reset", 32'(busy_o), 0);
    chk("R9 all_done in reset", 32'(all_done_o), 0);
    chk("R9 region_se in reset", 32'(region_se_o), 0);
    sel_i = '0;
    rst_n = 1'b1;
    tick();
    chk("R9 active_sel after reset", 32'(active_sel_o), 0);

    // Vector table: R2 / R3 / R5
    for (int v = 0; v < 10; v++) begin
      string tag;
      test_mode_i = VECS[v][15];
      sel_i       = VECS[v][13:10];
      scan_en_i   = 1'b0;
      tick();
      scan_en_i = VECS[v][14];
      #1;
      if (!VECS[v][15])            tag = "R3";
      else if (VECS[v][13:10] >= NR) tag = "R5";
      else                         tag = "R2";
      chk({tag, " region_se"}, 32'(region_se_o), 32'(VECS[v][7:0]));
      chk({tag, " sel_err"}, 32'(sel_err_o), 32'(VECS[v][9]));
      chk("R1 onehot0", 32'($countones(region_se_o) <= 1), 1);
    end

    // R4: select change during a shift is held off
    test_mode_i = 1'b1;
    scan_en_i = 1'b0;
    sel_i = 4'd2;
    tick();
    scan_en_i = 1'b1;
    sel_i = 4'd5;
    tick();
    tick();
    chk("R4 select held while shifting", 32'(active_sel_o), 2);
    chk("R4 region kept while shifting", 32'(region_se_o), 32'h04);
    scan_en_i = 1'b0;
    tick();
    chk("R4 select applied after shift", 32'(active_sel_o), 5);
    scan_en_i = 1'b1;
    #1;
    chk("R4 new region enabled", 32'(region_se_o), 32'h20);
    scan_en_i = 1'b0;

    // R8: auto mode idle
    auto_mode_i = 1'b1;
    tick();
    scan_en_i = 1'b1;
    #1;
    chk("R8 idle auto no region", 32'(region_se_o), 0);
    scan_en_i = 1'b0;
    session_done_i = 1'b1;
    tick();
    session_done_i = 1'b0;
    chk("R8 done ignored when idle busy", 32'(busy_o), 0);
    chk("R8 done ignored when idle all_done", 32'(all_done_o), 0);

    // R6: start and walk
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    chk("R6 busy after start", 32'(busy_o), 1);
    tick();
    chk("R6 region 0 applied", 32'(active_sel_o), 0);
    scan_en_i = 1'b1;
    #1;
    chk("R6 region 0 enabled", 32'(region_se_o), 32'h01);
    scan_en_i = 1'b0;

    for (int k = 0; k < NR; k++) begin
      if (k == 3) begin
        start_i = 1'b1;
        tick();
        start_i = 1'b0;
        tick();
        chk("R8 start while busy keeps region", 32'(active_sel_o), 3);
      end
      session_done_i = 1'b1;
      tick();
      session_done_i = 1'b0;
      if (k < NR - 1) begin
        chk("R6 still busy", 32'(busy_o), 1);
        tick();
        chk("R6 region advanced", 32'(active_sel_o), 32'(k + 1));
        scan_en_i = 1'b1;
        #1;
        chk("R6 advanced region enabled", 32'(region_se_o), 32'(1 << (k + 1)));
        scan_en_i = 1'b0;
      end else begin
        chk("R7 all_done raised", 32'(all_done_o), 1);
        chk("R7 busy dropped", 32'(busy_o), 0);
        tick();
        chk("R7 all_done single cycle", 32'(all_done_o), 0);
        scan_en_i = 1'b1;
        #1;
        chk("R7 no region after walk", 32'(region_se_o), 0);
        scan_en_i = 1'b0;
      end
    end

    // R3: leaving test mode in manual mode silences everything
    auto_mode_i = 1'b0;
    sel_i = 4'd6;
    tick();
    test_mode_i = 1'b0;
    scan_en_i = 1'b1;
    #1;
    chk("R3 test mode off", 32'(region_se_o), 0);
    scan_en_i = 1'b0;
    tick();
    finish_run();
  end

endmodule